// File: doc/BRIEF.md
# Self-Routing Banyan Switch Network

This block moves a set of fixed-size cells from N input ports to N output ports through a multistage network of 2x2 switching elements, with no central controller. Each input port presents a valid bit, a destination port number and a payload every clock. At every stage an element looks at one bit of a cell's destination and steers the cell to its upper or lower output. After log2(N) stages every cell that got through sits on the output port equal to its destination.

Two cells can reach the same element and ask for the same element output. The element then passes the cell from its upper input and drops the other. The network carries a per-input blocked mask alongside the cells, so the output wave tells the sender exactly which input ports lost their cell. Every stage is registered. A new wave of cells is taken every clock and appears log2(N) clocks later. There is no back-pressure: the input side has no ready, because the network accepts every wave, and the output side has no ready, because the sink must take each wave in the cycle it appears. A dropped cell is gone. Retrying it is the sender's job, using the blocked flags.

The network never blocks when the valid cells sit on a contiguous run of input ports and carry distinct destinations that rise with the input index. A sorting stage placed in front can therefore make the network collision-free.

Top module: `banyan_switch`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted wave has crossed the network, out_valid and out_blocked are all zero.
- R2: A wave presented in the cycle of clock edge k appears on the outputs after edge k+log2(N). One wave is accepted on every clock edge, back to back, with no idle cycles needed between waves.
- R3: The stage with index s (0 first) routes on destination bit log2(N)-1-s, so the MSB is used first. A bit of 0 takes the element's upper output (even position) and a bit of 1 takes the lower output (odd position). A delivered cell appears on out port index equal to its destination, with its payload unchanged.
- R4: Stages are joined by the perfect shuffle. A cell at position p moves to the position whose index is p rotated left by one bit, and element j then joins positions 2j (upper) and 2j+1 (lower). When both inputs of an element are valid and select the same output, the upper cell wins. The lower cell is dropped, and bit i of out_blocked is set in the same output wave, where i is the original input port of the dropped cell.
- R5: If the valid cells of a wave occupy a contiguous run of input ports and their destinations are distinct and strictly ascending with the input index, every cell is delivered and out_blocked is zero.
- R6: In every output wave, each valid input cell of the matching input wave is either delivered once or flagged in out_blocked, never both. Input ports with in_valid low are never flagged. So the count of out_valid ones plus the count of out_blocked ones equals the count of in_valid ones of that wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per input port: a cell is present |
| in_dest | input | N*log2(N) | Destination port of each input cell; port i uses bits [i*log2(N) +: log2(N)] |
| in_data | input | N*DW | Payload of each input cell; port i uses bits [i*DW +: DW] |
| out_valid | output | N | Per output port: a delivered cell is present |
| out_data | output | N*DW | Payload on each output port; port o uses bits [o*DW +: DW] |
| out_blocked | output | N | Per original input port: that port's cell was dropped in this wave |

## Verification
The assertions assume that in_valid stays low while reset is held. This matters because the conservation checks between stages compare a stage's count with the previous stage's count one clock earlier. Beyond that they assume nothing about the inputs, and any destination pattern, colliding or not, has to keep cells and blocked flags balanced. The collision-free property depends on the order of the inputs, so it is left to the stimulus, not to an assertion. The stimulus holds in_valid low during reset. It builds its ascending waves by picking a contiguous run of ports and a set of distinct destinations, and it sends unconstrained random waves only in a separate phase where collisions are expected.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

  // Perfect shuffle: rotate a position index left by one bit.
  function automatic int unsigned shuffle_pos(input int unsigned pos, input int unsigned bits);
    int unsigned span;
    span = (32'd1 << bits) - 32'd1;
    return ((pos << 1) | (pos >> (bits - 1))) & span;
  endfunction

endpackage

// File: rtl/banyan_elem.sv
module banyan_elem #(
  parameter int LW  = 3,
  parameter int DW  = 16,
  parameter int SEL = 2
) (
  input  logic                a_v,
  input  logic [LW-1:0]       a_dst,
  input  logic [LW-1:0]       a_src,
  input  logic [DW-1:0]       a_dat,
  input  logic                b_v,
  input  logic [LW-1:0]       b_dst,
  input  logic [LW-1:0]       b_src,
  input  logic [DW-1:0]       b_dat,
  output logic [1:0]          o_v,
  output logic [1:0][LW-1:0]  o_dst,
  output logic [1:0][LW-1:0]  o_src,
  output logic [1:0][DW-1:0]  o_dat,
  output logic                drop
);

  logic a_bit, b_bit, clash;

  assign a_bit = a_dst[SEL];
  assign b_bit = b_dst[SEL];
  assign clash = a_v && b_v && (a_bit == b_bit);
  assign drop  = clash;

  always_comb begin
    o_v   = '0;
    o_dst = '0;
    o_src = '0;
    o_dat = '0;
    if (b_v && !clash) begin
      o_v[b_bit]   = 1'b1;
      o_dst[b_bit] = b_dst;
      o_src[b_bit] = b_src;
      o_dat[b_bit] = b_dat;
    end
    if (a_v) begin
      o_v[a_bit]   = 1'b1;
      o_dst[a_bit] = a_dst;
      o_src[a_bit] = a_src;
      o_dat[a_bit] = a_dat;
    end
  end

  // R4: on a clash the upper cell owns the contested output
  always_comb begin
    if (clash) begin
      assert_upper_wins_R4: assert (o_src[a_bit] == a_src && o_dat[a_bit] == a_dat);
    end
  end

endmodule

// File: rtl/banyan_stage.sv
module banyan_stage
  import banyan_pkg::*;
#(
  parameter int N     = 8,
  parameter int LW    = 3,
  parameter int DW    = 16,
  parameter int STAGE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           in_v,
  input  logic [N-1:0][LW-1:0]   in_dst,
  input  logic [N-1:0][LW-1:0]   in_src,
  input  logic [N-1:0][DW-1:0]   in_dat,
  input  logic [N-1:0]           in_mask,
  output logic [N-1:0]           out_v,
  output logic [N-1:0][LW-1:0]   out_dst,
  output logic [N-1:0][LW-1:0]   out_src,
  output logic [N-1:0][DW-1:0]   out_dat,
  output logic [N-1:0]           out_mask
);

  localparam int HALF = N / 2;
  localparam int SEL  = LW - 1 - STAGE;

  logic [N-1:0]          sh_v;
  logic [N-1:0][LW-1:0]  sh_dst, sh_src;
  logic [N-1:0][DW-1:0]  sh_dat;

  logic [N-1:0]          nx_v;
  logic [N-1:0][LW-1:0]  nx_dst, nx_src;
  logic [N-1:0][DW-1:0]  nx_dat;
  logic [HALF-1:0]       drop;
  logic [N-1:0]          nx_mask;

  for (genvar p = 0; p < N; p++) begin : g_shuffle
    localparam int Q = int'(shuffle_pos(p, LW));
    assign sh_v[Q]   = in_v[p];
    assign sh_dst[Q] = in_dst[p];
    assign sh_src[Q] = in_src[p];
    assign sh_dat[Q] = in_dat[p];
  end

  for (genvar j = 0; j < HALF; j++) begin : g_elem
    banyan_elem #(.LW(LW), .DW(DW), .SEL(SEL)) u_elem (
      .a_v   (sh_v[2*j]),
      .a_dst (sh_dst[2*j]),
      .a_src (sh_src[2*j]),
      .a_dat (sh_dat[2*j]),
      .b_v   (sh_v[2*j+1]),
      .b_dst (sh_dst[2*j+1]),
      .b_src (sh_src[2*j+1]),
      .b_dat (sh_dat[2*j+1]),
      .o_v   (nx_v[2*j+1:2*j]),
      .o_dst (nx_dst[2*j+1:2*j]),
      .o_src (nx_src[2*j+1:2*j]),
      .o_dat (nx_dat[2*j+1:2*j]),
      .drop  (drop[j])
    );
  end

  always_comb begin
    nx_mask = in_mask;
    for (int j = 0; j < HALF; j++) begin
      if (drop[j]) nx_mask[sh_src[2*j+1]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v    <= '0;
      out_dst  <= '0;
      out_src  <= '0;
      out_dat  <= '0;
      out_mask <= '0;
    end else begin
      out_v    <= nx_v;
      out_dst  <= nx_dst;
      out_src  <= nx_src;
      out_dat  <= nx_dat;
      out_mask <= nx_mask;
    end
  end

  // R3: a registered cell sits on the element side named by its stage bit
  for (genvar p = 0; p < N; p++) begin : g_chk_side
    assert_side_matches_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_v[p] |-> (out_dst[p][SEL] == ((p % 2) == 1)));
  end

  if (STAGE > 0) begin : g_chk_flow
    // R6: cells plus flags are conserved across this stage
    assert_cells_conserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(out_v) + $countones(out_mask)) ==
      $past($countones(in_v) + $countones(in_mask)));
    // R4: a blocked flag, once raised, travels on to the next stage
    assert_flag_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_mask & $past(in_mask)) == $past(in_mask)));
  end

endmodule

// File: rtl/banyan_switch.sv
module banyan_switch #(
  parameter int N  = 8,
  parameter int DW = 16,
  localparam int LW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      in_valid,
  input  logic [N*LW-1:0]   in_dest,
  input  logic [N*DW-1:0]   in_data,
  output logic [N-1:0]      out_valid,
  output logic [N*DW-1:0]   out_data,
  output logic [N-1:0]      out_blocked
);

  logic [LW:0][N-1:0]          ch_v;
  logic [LW:0][N-1:0][LW-1:0]  ch_dst;
  logic [LW:0][N-1:0][LW-1:0]  ch_src;
  logic [LW:0][N-1:0][DW-1:0]  ch_dat;
  logic [LW:0][N-1:0]          ch_mask;

  assign ch_v[0]    = in_valid;
  assign ch_dst[0]  = in_dest;
  assign ch_dat[0]  = in_data;
  assign ch_mask[0] = '0;

  for (genvar p = 0; p < N; p++) begin : g_src
    assign ch_src[0][p] = LW'(p);
  end

  for (genvar s = 0; s < LW; s++) begin : g_stage
    banyan_stage #(.N(N), .LW(LW), .DW(DW), .STAGE(s)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (ch_v[s]),
      .in_dst   (ch_dst[s]),
      .in_src   (ch_src[s]),
      .in_dat   (ch_dat[s]),
      .in_mask  (ch_mask[s]),
      .out_v    (ch_v[s+1]),
      .out_dst  (ch_dst[s+1]),
      .out_src  (ch_src[s+1]),
      .out_dat  (ch_dat[s+1]),
      .out_mask (ch_mask[s+1])
    );
  end

  assign out_valid   = ch_v[LW];
  assign out_data    = ch_dat[LW];
  assign out_blocked = ch_mask[LW];

  for (genvar p = 0; p < N; p++) begin : g_chk_out
    // R3: a delivered cell leaves on the port named by its destination
    assert_lands_on_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] |-> (ch_dst[LW][p] == LW'(p)));
    // R6: a delivered cell's source is never also flagged as blocked
    assert_not_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] |-> !out_blocked[ch_src[LW][p]]);
  end

endmodule

// File: tb/banyan_switch_bench.sv
module banyan_switch_bench;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam int LW = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N*LW-1:0]   in_dest = '0;
  logic [N*DW-1:0]   in_data = '0;
  logic [N-1:0]      out_valid;
  logic [N*DW-1:0]   out_data;
  logic [N-1:0]      out_blocked;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [N-1:0]    q_v[$];
  logic [N-1:0]    q_b[$];
  logic [N-1:0]    q_in[$];
  logic [N*DW-1:0] q_d[$];
  bit              q_s[$];

  always #5 clk = ~clk;

  banyan_switch #(.N(N), .DW(DW)) u_banyan_switch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_blocked(out_blocked)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rotl(input int unsigned p);
    return ((p << 1) | (p >> (LW - 1))) & (N - 1);
  endfunction

  // Behavioural reference: track which input occupies each position.
  task automatic model(input logic [N-1:0] v, input logic [N*LW-1:0] d,
                       input logic [N*DW-1:0] dat, output logic [N-1:0] ev,
                       output logic [N-1:0] eb, output logic [N*DW-1:0] ed);
    int occ[N];
    int sh[N];
    ev = '0; eb = '0; ed = '0;
    for (int p = 0; p < N; p++) occ[p] = v[p] ? p : -1;
    for (int s = 0; s < LW; s++) begin
      for (int p = 0; p < N; p++) sh[rotl(p)] = occ[p];
      for (int p = 0; p < N; p++) occ[p] = -1;
      for (int j = 0; j < N/2; j++) begin
        int a, b, ab, bb;
        a = sh[2*j]; b = sh[2*j+1];
        ab = (a >= 0) ? int'((d[a*LW +: LW] >> (LW-1-s)) & 1) : 0;
        bb = (b >= 0) ? int'((d[b*LW +: LW] >> (LW-1-s)) & 1) : 0;
        if (a >= 0) occ[2*j + ab] = a;
        if (b >= 0) begin
          if (a >= 0 && ab == bb) eb[b] = 1'b1;
          else occ[2*j + bb] = b;
        end
      end
    end
    for (int p = 0; p < N; p++) begin
      if (occ[p] >= 0) begin
        ev[p] = 1'b1;
        ed[p*DW +: DW] = dat[occ[p]*DW +: DW];
      end
    end
  endtask

  task automatic compare_front();
    logic [N-1:0] ev, eb, ein;
    logic [N*DW-1:0] ed;
    bit srt;
    if (q_v.size() != LW) return;
    ev = q_v.pop_front(); eb = q_b.pop_front(); ein = q_in.pop_front();
    ed = q_d.pop_front(); srt = q_s.pop_front();
    check(out_valid == ev, "R2/R3", "out_valid", 128'(out_valid), 128'(ev));
    for (int p = 0; p < N; p++) begin
      if (ev[p])
        check(out_data[p*DW +: DW] == ed[p*DW +: DW], "R3", "payload on port",
              128'(out_data[p*DW +: DW]), 128'(ed[p*DW +: DW]));
    end
    check(out_blocked == eb, "R4", "out_blocked", 128'(out_blocked), 128'(eb));
    check($countones(out_valid) + $countones(out_blocked) == $countones(ein) &&
          (out_blocked & ~ein) == '0, "R6", "delivered plus blocked",
          128'($countones(out_valid) + $countones(out_blocked)), 128'($countones(ein)));
    if (srt) check(out_blocked == '0 && out_valid == ein_dests(ein, ed, ev), "R5",
                   "ascending wave blocked", 128'(out_blocked), 128'(0));
  endtask

  function automatic logic [N-1:0] ein_dests(input logic [N-1:0] ein,
                                             input logic [N*DW-1:0] ed,
                                             input logic [N-1:0] ev);
    if ($countones(ev) == $countones(ein)) return ev;
    return ~out_valid;
  endfunction

  // Drive a wave (caller is at a negedge) and queue its expectation.
  task automatic wave(input logic [N-1:0] v, input logic [N*LW-1:0] d,
                      input logic [N*DW-1:0] dat, input bit srt);
    logic [N-1:0] ev, eb;
    logic [N*DW-1:0] ed;
    model(v, d, dat, ev, eb, ed);
    in_valid = v; in_dest = d; in_data = dat;
    q_v.push_back(ev); q_b.push_back(eb); q_in.push_back(v);
    q_d.push_back(ed); q_s.push_back(srt);
  endtask

  task automatic step(input logic [N-1:0] v, input logic [N*LW-1:0] d,
                      input logic [N*DW-1:0] dat, input bit srt);
    @(negedge clk);
    compare_front();
    wave(v, d, dat, srt);
  endtask

  function automatic logic [N*DW-1:0] rand_data();
    logic [N*DW-1:0] r;
    for (int p = 0; p < N; p++) r[p*DW +: DW] = DW'($urandom);
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [N*LW-1:0] d;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == '0 && out_blocked == '0, "R1", "outputs in reset",
          128'({out_valid, out_blocked}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == '0 && out_blocked == '0, "R1", "outputs after release",
          128'({out_valid, out_blocked}), 128'(0));
    wave('0, '0, '0, 1'b0);

    // R4: inputs 0 and 4 meet in element 0 of the first stage, both bit 0
    d = '0; d[0*LW +: LW] = 3'd0; d[4*LW +: LW] = 3'd1;
    step(8'h11, d, rand_data(), 1'b0);
    step('0, '0, '0, 1'b0);
    step('0, '0, '0, 1'b0);
    @(negedge clk);
    check(out_blocked == 8'h10, "R4", "lower input blocked", 128'(out_blocked), 128'(8'h10));
    check(out_valid == 8'h01, "R4", "upper cell delivered", 128'(out_valid), 128'(8'h01));
    compare_front();
    wave('0, '0, '0, 1'b0);

    // R2: lone cell input 3 -> port 5, visible exactly LW edges later
    d = '0; d[3*LW +: LW] = 3'd5;
    step(8'h08, d, rand_data(), 1'b0);
    for (int k = 0; k < LW + 1; k++) step('0, '0, '0, 1'b0);

    // R5: ascending distinct destinations on contiguous ports, back to back
    for (int w = 0; w < 300; w++) begin
      int k, start, idx;
      logic [N-1:0] dm, v;
      k = 1 + int'($urandom_range(N - 1));
      start = int'($urandom_range(N - k));
      do dm = N'($urandom); while ($countones(dm) != k);
      v = '0; d = '0; idx = start;
      for (int q = 0; q < N; q++) begin
        if (dm[q]) begin
          v[idx] = 1'b1;
          d[idx*LW +: LW] = LW'(q);
          idx++;
        end
      end
      step(v, d, rand_data(), 1'b1);
    end

    // R3 R4 R6: unconstrained random waves, collisions expected
    for (int w = 0; w < 400; w++) begin
      step(N'($urandom), (N*LW)'({$urandom, $urandom}), rand_data(), 1'b0);
    end

    // full-load waves with all cells on one destination half
    for (int w = 0; w < 20; w++) begin
      d = '0;
      for (int p = 0; p < N; p++) d[p*LW +: LW] = LW'($urandom_range(N/2 - 1));
      step('1, d, rand_data(), 1'b0);
    end

    for (int k = 0; k < LW + 1; k++) step('0, '0, '0, 1'b0);
    finish_run();
  end

endmodule